// File: doc/BRIEF.md
# Lazy One-Step Block Migration Controller

This block sits beside a shared, banked last-level cache whose sixteen bankclusters are laid out around eight processors. Every cache hit is shown to it as a cluster number, the id of the processor that made the request, and the block address. From those two location facts alone it works out whether the block should take one step closer to the requester along a fixed path that runs through the shared middle of the array. It keeps no record of a block's past accesses.

A move is not issued at once. It is placed in a small table of pending moves, each with a countdown, and a command naming source and destination clusters is emitted only when the countdown has run out. If another processor hits the same block while the move is waiting, the move is dropped. This keeps blocks used by several processors from being pulled back and forth. While the cache is resolving a possible false miss, a suspend input freezes every countdown and holds back every command.

Top module: `lazy_migrate_ctrl`

## Requirements
- R1: Cluster numbering: cluster c in 0..7 is the local cluster of processor c; intermediate cluster of processor p is 8 + p/2; center cluster of processor p is 12 + p/2 (integer division).
- R2: For a hit by processor p in cluster c, the destination is: own intermediate -> own local; own center -> own intermediate; any other center -> own center; another intermediate 8+k -> center 12+k; another processor's local q -> intermediate 8+q/2.
- R3: A hit in the requester's own local cluster schedules no move.
- R4: A scheduled move produces migValid high for one cycle, with migSrc = hit cluster, migDst from R2 and migAddr = hit address, exactly DELAY+1 rising edges after the edge that sampled the hit, provided suspend stays low.
- R5: A hit on a block with a pending move by a processor other than the one that scheduled it cancels the move; no command is ever issued for it.
- R6: A repeated hit on a block with a pending move by the same processor neither restarts the countdown nor schedules a second move.
- R7: When all DEPTH pending slots are occupied, a new move is discarded and the pending moves are unaffected.
- R8: While suspend is high no command is issued and no countdown advances; counting resumes from the held value once suspend falls.
- R9: After reset, migValid is low and the pending table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hitValid | input | 1 | A cache hit is presented this cycle |
| hitCluster | input | 4 | Cluster holding the hit block |
| reqCpu | input | 3 | Requesting processor id |
| hitAddr | input | ADDR_W | Block address of the hit |
| suspend | input | 1 | Freeze all pending moves |
| migValid | output | 1 | Migration command strobe |
| migSrc | output | 4 | Source cluster of the command |
| migDst | output | 4 | Destination cluster of the command |
| migAddr | output | ADDR_W | Block address of the command |

## Verification
A corrupted countdown or slot field shows at the ports only late, as a command one or more cycles off the DELAY+1 mark or carrying the wrong cluster pair. For that reason the bench checks every cycle against a cycle-accurate model, not only when a command arrives. A stuck or lost valid bit shows as a missing command, a command after a cancel, or a drop when the table is not really full. Each of these becomes visible within DELAY+1 cycles of the hit that exposes it. Random hits are drawn from a small address pool, so cancels, repeats and full-table drops occur often alongside the directed cases.

// File: rtl/migr_pkg.sv
package migr_pkg;
  localparam int CPU_W  = 3;
  localparam int CL_W   = 4;
  localparam int SLOT_W = 4;   // supports up to 16 pending slots

  typedef logic [CL_W-1:0] clId_t;
  typedef logic [CPU_W-1:0] cpuId_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              allocEn;
    logic [SLOT_W-1:0] allocIdx;
    logic              cancelEn;
    logic [SLOT_W-1:0] cancelIdx;
    logic              issueEn;
    logic [SLOT_W-1:0] issueIdx;
  } slotCmd_t;

  function automatic clId_t localOf(input cpuId_t cpu);
    return {1'b0, cpu};
  endfunction

  function automatic clId_t interOf(input cpuId_t cpu);
    return {2'b10, cpu[2:1]};
  endfunction

  function automatic clId_t centerOf(input cpuId_t cpu);
    return {2'b11, cpu[2:1]};
  endfunction
endpackage

// File: rtl/mig_route.sv
module mig_route
  import migr_pkg::*;
(
  input  clId_t  hitCluster,
  input  cpuId_t reqCpu,
  output logic   moveNeeded,
  output clId_t  dstCluster
);
  always_comb begin
    moveNeeded = 1'b1;
    dstCluster = hitCluster;
    if (hitCluster == localOf(reqCpu)) begin
      moveNeeded = 1'b0;
    end else if (hitCluster == interOf(reqCpu)) begin
      dstCluster = localOf(reqCpu);
    end else if (hitCluster == centerOf(reqCpu)) begin
      dstCluster = interOf(reqCpu);
    end else if (hitCluster[3:2] == 2'b11) begin
      dstCluster = centerOf(reqCpu);
    end else if (hitCluster[3:2] == 2'b10) begin
      dstCluster = {2'b11, hitCluster[1:0]};
    end else begin
      dstCluster = {2'b10, hitCluster[2:1]};
    end
  end
endmodule

// File: rtl/mig_sched_ctrl.sv
module mig_sched_ctrl
  import migr_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hitValid,
  input  logic             moveNeeded,
  input  logic             suspend,
  input  logic [DEPTH-1:0] vldVec,
  input  logic [DEPTH-1:0] matchVec,
  input  logic [DEPTH-1:0] sameCpuVec,
  input  logic [DEPTH-1:0] expiredVec,
  output slotCmd_t         cmd
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             anyMatch, anyFree, anyExp;
  logic [IDX_W-1:0] matchIdx, freeIdx, expIdx;
  logic             cancelNow;

  always_comb begin
    anyMatch = 1'b0;
    matchIdx = '0;
    anyFree  = 1'b0;
    freeIdx  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        anyMatch = 1'b1;
        matchIdx = IDX_W'(i);
      end
      if (!vldVec[i]) begin
        anyFree = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  assign cancelNow = hitValid && anyMatch && !sameCpuVec[matchIdx];

  always_comb begin
    anyExp = 1'b0;
    expIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (expiredVec[i] && !(cancelNow && (matchIdx == IDX_W'(i)))) begin
        anyExp = 1'b1;
        expIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    cmd           = '0;
    cmd.cancelEn  = cancelNow;
    cmd.cancelIdx = SLOT_W'(matchIdx);
    cmd.allocEn   = hitValid && !anyMatch && moveNeeded && anyFree;
    cmd.allocIdx  = SLOT_W'(freeIdx);
    cmd.issueEn   = anyExp && !suspend;
    cmd.issueIdx  = SLOT_W'(expIdx);
  end

  // R7
  alloc_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.allocEn |-> !vldVec[IDX_W'(cmd.allocIdx)]);

  // R4
  issue_expired_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.issueEn |-> expiredVec[IDX_W'(cmd.issueIdx)]);
endmodule

// File: rtl/mig_pend_store.sv
module mig_pend_store
  import migr_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DEPTH  = 4,
  parameter int DELAY  = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              suspend,
  input  logic [ADDR_W-1:0] hitAddr,
  input  cpuId_t            reqCpu,
  input  clId_t             hitCluster,
  input  clId_t             dstCluster,
  input  slotCmd_t          cmd,
  output logic [DEPTH-1:0]  vldVec,
  output logic [DEPTH-1:0]  matchVec,
  output logic [DEPTH-1:0]  sameCpuVec,
  output logic [DEPTH-1:0]  expiredVec,
  output logic              migValid,
  output clId_t             migSrc,
  output clId_t             migDst,
  output logic [ADDR_W-1:0] migAddr
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TMR_W = $clog2(DELAY + 1);

  logic [ADDR_W-1:0] slotAddr [DEPTH];
  cpuId_t            slotCpu  [DEPTH];
  clId_t             slotSrc  [DEPTH];
  clId_t             slotDst  [DEPTH];
  logic [TMR_W-1:0]  slotTmr  [DEPTH];

  logic [IDX_W-1:0] issSlot;
  assign issSlot = IDX_W'(cmd.issueIdx);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic allocHere, dropHere;
    assign allocHere = cmd.allocEn && (IDX_W'(cmd.allocIdx) == IDX_W'(i));
    assign dropHere  = (cmd.cancelEn && (IDX_W'(cmd.cancelIdx) == IDX_W'(i))) ||
                       (cmd.issueEn  && (issSlot == IDX_W'(i)));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vldVec[i]   <= 1'b0;
        slotAddr[i] <= '0;
        slotCpu[i]  <= '0;
        slotSrc[i]  <= '0;
        slotDst[i]  <= '0;
        slotTmr[i]  <= '0;
      end else if (allocHere) begin
        vldVec[i]   <= 1'b1;
        slotAddr[i] <= hitAddr;
        slotCpu[i]  <= reqCpu;
        slotSrc[i]  <= hitCluster;
        slotDst[i]  <= dstCluster;
        slotTmr[i]  <= TMR_W'(DELAY);
      end else if (dropHere) begin
        vldVec[i]   <= 1'b0;
      end else if (vldVec[i] && !suspend && (slotTmr[i] != '0)) begin
        slotTmr[i]  <= slotTmr[i] - 1'b1;
      end
    end

    assign matchVec[i]   = vldVec[i] && (slotAddr[i] == hitAddr);
    assign sameCpuVec[i] = (slotCpu[i] == reqCpu);
    assign expiredVec[i] = vldVec[i] && (slotTmr[i] == '0);

    // R8
    tmr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (suspend && vldVec[i] && !dropHere) |=> (slotTmr[i] == $past(slotTmr[i])));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      migValid <= 1'b0;
      migSrc   <= '0;
      migDst   <= '0;
      migAddr  <= '0;
    end else begin
      migValid <= cmd.issueEn;
      if (cmd.issueEn) begin
        migSrc  <= slotSrc[issSlot];
        migDst  <= slotDst[issSlot];
        migAddr <= slotAddr[issSlot];
      end
    end
  end

  // R8
  susp_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    suspend |=> !migValid);
endmodule

// File: rtl/lazy_migrate_ctrl.sv
module lazy_migrate_ctrl
  import migr_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DEPTH  = 4,
  parameter int DELAY  = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hitValid,
  input  logic [3:0]        hitCluster,
  input  logic [2:0]        reqCpu,
  input  logic [ADDR_W-1:0] hitAddr,
  input  logic              suspend,
  output logic              migValid,
  output logic [3:0]        migSrc,
  output logic [3:0]        migDst,
  output logic [ADDR_W-1:0] migAddr
);
  logic             moveNeeded;
  clId_t            dstCluster;
  slotCmd_t         cmd;
  logic [DEPTH-1:0] vldVec, matchVec, sameCpuVec, expiredVec;

  mig_route u_route (
    .hitCluster (hitCluster),
    .reqCpu     (reqCpu),
    .moveNeeded (moveNeeded),
    .dstCluster (dstCluster)
  );

  mig_sched_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hitValid   (hitValid),
    .moveNeeded (moveNeeded),
    .suspend    (suspend),
    .vldVec     (vldVec),
    .matchVec   (matchVec),
    .sameCpuVec (sameCpuVec),
    .expiredVec (expiredVec),
    .cmd        (cmd)
  );

  mig_pend_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .DELAY(DELAY)) u_store (
    .clk        (clk),
    .rstN       (rstN),
    .suspend    (suspend),
    .hitAddr    (hitAddr),
    .reqCpu     (reqCpu),
    .hitCluster (hitCluster),
    .dstCluster (dstCluster),
    .cmd        (cmd),
    .vldVec     (vldVec),
    .matchVec   (matchVec),
    .sameCpuVec (sameCpuVec),
    .expiredVec (expiredVec),
    .migValid   (migValid),
    .migSrc     (migSrc),
    .migDst     (migDst),
    .migAddr    (migAddr)
  );

  // R3
  own_local_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitValid && (hitCluster == {1'b0, reqCpu})) |-> !moveNeeded);

  // R2
  move_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    migValid |-> (migSrc != migDst));
endmodule

// File: tb/sim_lazy_migrate_ctrl.sv
`timescale 1ns/1ps
module sim_lazy_migrate_ctrl;
  localparam int AW = 16;
  localparam int DP = 4;
  localparam int DL = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hitValid = 1'b0;
  logic [3:0]    hitCluster = '0;
  logic [2:0]    reqCpu = '0;
  logic [AW-1:0] hitAddr = '0;
  logic          suspend = 1'b0;
  logic          migValid;
  logic [3:0]    migSrc, migDst;
  logic [AW-1:0] migAddr;

  always #4 clk = ~clk;   // 125 MHz

  lazy_migrate_ctrl #(.ADDR_W(AW), .DEPTH(DP), .DELAY(DL)) u0 (
    .clk(clk), .rstN(rstN), .hitValid(hitValid), .hitCluster(hitCluster),
    .reqCpu(reqCpu), .hitAddr(hitAddr), .suspend(suspend),
    .migValid(migValid), .migSrc(migSrc), .migDst(migDst), .migAddr(migAddr));

  int    nVec = 0;
  int    nBad = 0;
  string curReq = "R9";
  bit    done = 1'b0;

  // reference model state
  bit            mVld [DP];
  logic [AW-1:0] mAddr[DP];
  logic [2:0]    mCpu [DP];
  logic [3:0]    mSrc [DP];
  logic [3:0]    mDst [DP];
  int            mTmr [DP];
  bit            eValid;
  logic [3:0]    eSrc, eDst;
  logic [AW-1:0] eAddr;

  // expected one-step destination from R1/R2; returns 0 for own local (R3)
  function automatic bit refRoute(input logic [3:0] cl, input logic [2:0] p,
                                  output logic [3:0] dst);
    int pair;
    pair = int'(p) / 2;
    dst = cl;
    if (int'(cl) == int'(p)) return 1'b0;
    if (int'(cl) == 8 + pair)  begin dst = 4'(int'(p));    return 1'b1; end
    if (int'(cl) == 12 + pair) begin dst = 4'(8 + pair);   return 1'b1; end
    if (cl >= 4'd12)           begin dst = 4'(12 + pair);  return 1'b1; end
    if (cl >= 4'd8)            begin dst = cl + 4'd4;      return 1'b1; end
    dst = 4'(8 + int'(cl) / 2);
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    int cancelI, issI, freeI, hitI;
    bit mv;
    logic [3:0] d;
    if (!rstN) begin
      for (int i = 0; i < DP; i++) mVld[i] = 1'b0;
      eValid = 1'b0;
    end else begin
      cancelI = -1; issI = -1; freeI = -1; hitI = -1;
      for (int i = 0; i < DP; i++) if (mVld[i] && mAddr[i] == hitAddr) hitI = i;
      if (hitValid && hitI >= 0 && mCpu[hitI] != reqCpu) cancelI = hitI;
      if (!suspend)
        for (int i = DP - 1; i >= 0; i--)
          if (mVld[i] && mTmr[i] == 0 && i != cancelI) issI = i;
      mv = refRoute(hitCluster, reqCpu, d);
      if (hitValid && hitI < 0 && mv)
        for (int i = DP - 1; i >= 0; i--) if (!mVld[i]) freeI = i;
      eValid = (issI >= 0);
      if (issI >= 0) begin
        eSrc = mSrc[issI]; eDst = mDst[issI]; eAddr = mAddr[issI];
        mVld[issI] = 1'b0;
      end
      if (cancelI >= 0) mVld[cancelI] = 1'b0;
      for (int i = 0; i < DP; i++)
        if (mVld[i] && !suspend && mTmr[i] > 0) mTmr[i]--;
      if (freeI >= 0) begin
        mVld[freeI] = 1'b1; mAddr[freeI] = hitAddr; mCpu[freeI] = reqCpu;
        mSrc[freeI] = hitCluster; mDst[freeI] = d; mTmr[freeI] = DL;
      end
    end
  end

  task automatic compare();
    nVec++;
    if (migValid !== eValid) begin
      nBad++;
      $display("FAIL %s: migValid=%b expected %b at %0t", curReq, migValid, eValid, $time);
    end else if (eValid && (migSrc !== eSrc || migDst !== eDst || migAddr !== eAddr)) begin
      nBad++;
      $display("FAIL %s: cmd src=%0d dst=%0d addr=%h expected src=%0d dst=%0d addr=%h",
               curReq, migSrc, migDst, migAddr, eSrc, eDst, eAddr);
    end
  endtask

  task automatic step(input bit hv, input int cl, input int cpu, input int ad, input bit su);
    @(negedge clk);
    compare();
    hitValid = hv; hitCluster = 4'(cl); reqCpu = 3'(cpu); hitAddr = AW'(ad); suspend = su;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 0, 0, 0, 1'b0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    nBad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R9"; idle(4);

    curReq = "R3"; step(1, 2, 2, 'h10, 0); step(1, 7, 7, 'h11, 0); idle(DL + 4);

    // chain for processor 5: own local 5, inter 10, center 14
    curReq = "R2"; step(1, 0, 5, 'h20, 0); idle(DL + 3);
    curReq = "R2"; step(1, 9, 5, 'h21, 0); idle(DL + 3);
    curReq = "R2"; step(1, 12, 5, 'h22, 0); idle(DL + 3);
    curReq = "R1"; step(1, 14, 5, 'h23, 0); idle(DL + 3);
    curReq = "R1"; step(1, 10, 5, 'h24, 0); idle(DL + 3);
    curReq = "R2"; step(1, 4, 5, 'h25, 0); idle(DL + 3);   // partner local -> own inter
    curReq = "R4"; step(1, 15, 0, 'h26, 0); idle(DL + 3);

    curReq = "R5"; step(1, 12, 1, 'h30, 0); idle(3); step(1, 12, 4, 'h30, 0); idle(DL + 4);
    curReq = "R5"; step(1, 13, 6, 'h31, 0); idle(DL - 1); step(1, 13, 2, 'h31, 0); idle(4);

    curReq = "R6"; step(1, 12, 1, 'h40, 0); idle(5); step(1, 12, 1, 'h40, 0); idle(DL + 4);

    curReq = "R7";
    for (int k = 0; k < DP + 1; k++) step(1, 8, 7, 'h50 + k, 0);
    idle(DL + DP + 4);

    curReq = "R8";
    step(1, 11, 0, 'h60, 0); idle(5);
    for (int k = 0; k < 20; k++) step(0, 0, 0, 0, 1);
    idle(DL + 4);
    step(1, 11, 0, 'h61, 0); idle(DL - 1);
    for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 1);
    idle(4);

    curReq = "R2";
    void'($urandom(32'h5eed1234));
    for (int k = 0; k < 4000; k++) begin
      step(($urandom % 2) == 0, int'($urandom % 16), int'($urandom % 8),
           int'($urandom % 6), ($urandom % 20) == 0);
    end
    idle(DL + 8);

    curReq = "R9";
    rstN = 1'b0; @(negedge clk); rstN = 1'b1;
    idle(3);
    summary();
  end
endmodule